// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Queue

This block is a direct-mapped data cache of 1 KB that sits between a processor port and a slow word-wide memory. Lines are 32 bytes (eight 32-bit words). Loads that find their line answer in the cycle they are presented. Loads that miss stall while the controller reads the whole line from memory, one word per memory transaction, and then complete from the refreshed line.

Stores never allocate. A store updates the cached copy only when its line is already resident, and it always enters a four-entry first-in first-out queue. The queue drains to memory on its own, one entry per memory transaction, in the order the stores arrived. The processor waits on a store only when that queue is full. A load miss does not start its line read while any queued store still targets the same line, so the refill never brings back data older than a store the processor has already issued.

Both sides share one memory port that uses a request/acknowledge handshake. A request and its address, data and byte enables stay steady until the memory acknowledges. Reset is asynchronous and active low, and it is released through a two-stage synchronizer.

Top module: `wtc_top`

## Requirements
- R1: The address is split as offset = bits 4:0, line index = bits 9:5, tag = bits 31:10, word select = bits 4:2. Each address maps to exactly one line. Two blocks with the same index and different tags evict each other.
- R2: A load whose line is valid and whose stored tag matches raises cpu_ready in the same cycle as cpu_req, returns the selected word on cpu_rdata, and issues no memory read.
- R3: A load miss keeps cpu_ready low and reads the eight words of the block from memory in ascending address order, starting at the block base. It then marks the line valid under the new tag and completes from the line. Every memory request holds mem_addr and mem_we steady until mem_ack.
- R4: A store that hits merges cpu_wdata into the cached word under cpu_be, where bit i covers data bits 8i+7:8i. A following load sees the merged word.
- R5: A store that misses leaves the line's tag and data unchanged. The block already resident at that index still hits, and the stored block is not made resident.
- R6: Every accepted store is queued for memory. A store is accepted in the cycle it is presented whenever the queue is not full.
- R7: The queue holds 4 entries. While it is full, cpu_ready stays low for a store until a queued write completes at memory.
- R8: Queued stores reach memory one at a time, in arrival order, each with mem_we = 1, its word-aligned address, its data and its byte enables. The final memory image equals every store applied in program order.
- R9: A load miss issues no memory read while any queued store targets the same 32-byte block. Its returned word includes those stores.
- R10: After reset every line is invalid and the queue is empty. No memory request appears until the processor gives the block work, and the first load misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = queued store drain, 0 = line read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Drain write data |
| mem_be | output | 4 | Drain byte enables (all ones on reads) |
| mem_rdata | input | 32 | Read data, sampled with mem_ack |
| mem_ack | input | 1 | Memory completes the current transaction |

## Verification
The assertions check several rules on every cycle:
- a full queue refuses stores, and an accepted store leaves the queue non-empty;
- a line read never starts while a queued store covers the missed block;
- memory requests hold steady until acknowledged;
- a completing load never overlaps a memory read;
- the port stays quiet during reset.

Data correctness can only be shown by the bench's scenarios. These cover byte-merged hits, write-around misses that keep the resident line, the eviction of a conflicting tag, and the ascending order of the refill words. They also cover the arrival order of drained stores, and the final memory image compared with a shadow copy after a long mixed run with varying memory latency.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 32;
  localparam int CACHE_BYTES = 1024;
  localparam int BLOCK_BYTES = 32;
  localparam int WB_DEPTH    = 4;

  localparam int BE_W    = DATA_W / 8;
  localparam int BSEL_W  = $clog2(BE_W);
  localparam int OFF_W   = $clog2(BLOCK_BYTES);
  localparam int LINES   = CACHE_BYTES / BLOCK_BYTES;
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int WPB     = BLOCK_BYTES / BE_W;
  localparam int WSEL_W  = $clog2(WPB);
  localparam int WADDR_W = ADDR_W - BSEL_W;
  localparam int BLK_W   = ADDR_W - OFF_W;

  typedef struct packed {
    logic [WADDR_W-1:0] waddr;
    logic [DATA_W-1:0]  data;
    logic [BE_W-1:0]    be;
  } wb_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FILL = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/wtc_lines.sv
module wtc_lines
  import wtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_wsel,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_word,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [WSEL_W-1:0] upd_wsel,
  input  logic [DATA_W-1:0] upd_data,
  input  logic [BE_W-1:0]   upd_be,
  input  logic              fill_en,
  input  logic              fill_done,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [WSEL_W-1:0] fill_wsel,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [TAG_W-1:0]  fill_tag
);
  logic [LINES-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES][WPB];

  always_comb begin
    valid_d = valid_q;
    if (fill_done) valid_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Tag and data arrays carry no reset; the valid bits qualify them.
  always_ff @(posedge clk) begin
    if (fill_done) tag_q[fill_idx] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      data_q[fill_idx][fill_wsel] <= fill_data;
    end else if (upd_en) begin
      for (int b = 0; b < BE_W; b++) begin
        if (upd_be[b]) data_q[upd_idx][upd_wsel][8*b +: 8] <= upd_data[8*b +: 8];
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_word  = data_q[rd_idx][rd_wsel];
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf
  import wtc_pkg::*;
#(
  parameter int DEPTH = WB_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  wb_entry_t        push_ent,
  input  logic             pop,
  output wb_entry_t        head,
  output logic             full,
  output logic             empty,
  input  logic [BLK_W-1:0] probe_blk,
  output logic             probe_hit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int REL_W = PTR_W + 2;

  wb_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] slot_hit;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    if (pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
    if (push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= push_ent;
  end

  // A slot is live when its distance from the read pointer is below the count.
  for (genvar g = 0; g < DEPTH; g++) begin : g_probe
    logic [REL_W-1:0] rel;
    assign rel = (REL_W'(g) >= REL_W'(rd_q)) ? REL_W'(g) - REL_W'(rd_q)
                                             : REL_W'(g) + REL_W'(DEPTH) - REL_W'(rd_q);
    assign slot_hit[g] = (rel < REL_W'(cnt_q)) &&
                         (slot_q[g].waddr[WADDR_W-1 -: BLK_W] == probe_blk);
  end

  assign probe_hit = |slot_hit;
  assign head      = slot_q[rd_q];
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
endmodule

// File: rtl/wtc_top.sv
module wtc_top
  import wtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [BE_W-1:0]   cpu_be,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  ctl_state_t        state_q, state_d;
  logic [BLK_W-1:0]  miss_blk_q, miss_blk_d;
  logic [WSEL_W-1:0] fill_cnt_q, fill_cnt_d;
  logic              drain_busy_q, drain_busy_d;

  logic [TAG_W-1:0]  c_tag;
  logic [IDX_W-1:0]  c_idx;
  logic [WSEL_W-1:0] c_wsel;
  logic              unused_low_addr;
  logic              line_valid, hit;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_word;
  logic              in_idle, push, fill_go, drain_go, fill_en, fill_last;
  logic              wb_full, wb_empty, wb_probe_hit;
  wb_entry_t         wb_head, wb_new;

  assign c_tag           = cpu_addr[ADDR_W-1 -: TAG_W];
  assign c_idx           = cpu_addr[OFF_W +: IDX_W];
  assign c_wsel          = cpu_addr[BSEL_W +: WSEL_W];
  assign unused_low_addr = ^cpu_addr[BSEL_W-1:0];

  assign hit       = line_valid && (line_tag == c_tag);
  assign in_idle   = (state_q == ST_IDLE);
  assign cpu_ready = in_idle && (cpu_we ? !wb_full : hit);
  assign cpu_rdata = line_word;
  assign push      = in_idle && cpu_req && cpu_we && !wb_full;

  assign wb_new.waddr = cpu_addr[ADDR_W-1:BSEL_W];
  assign wb_new.data  = cpu_wdata;
  assign wb_new.be    = cpu_be;

  assign fill_go   = (state_q == ST_WAIT) && !drain_busy_q && !wb_probe_hit;
  assign drain_go  = !drain_busy_q && !wb_empty && (state_q != ST_FILL) && !fill_go;
  assign fill_en   = (state_q == ST_FILL) && mem_ack;
  assign fill_last = (fill_cnt_q == WSEL_W'(WPB - 1));

  wtc_lines u_lines (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .rd_idx    (c_idx),
    .rd_wsel   (c_wsel),
    .rd_valid  (line_valid),
    .rd_tag    (line_tag),
    .rd_word   (line_word),
    .upd_en    (push && hit),
    .upd_idx   (c_idx),
    .upd_wsel  (c_wsel),
    .upd_data  (cpu_wdata),
    .upd_be    (cpu_be),
    .fill_en   (fill_en),
    .fill_done (fill_en && fill_last),
    .fill_idx  (miss_blk_q[IDX_W-1:0]),
    .fill_wsel (fill_cnt_q),
    .fill_data (mem_rdata),
    .fill_tag  (miss_blk_q[BLK_W-1 -: TAG_W])
  );

  wtc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .push      (push),
    .push_ent  (wb_new),
    .pop       (drain_busy_q && mem_ack),
    .head      (wb_head),
    .full      (wb_full),
    .empty     (wb_empty),
    .probe_blk (miss_blk_q),
    .probe_hit (wb_probe_hit)
  );

  always_comb begin
    state_d      = state_q;
    miss_blk_d   = miss_blk_q;
    fill_cnt_d   = fill_cnt_q;
    drain_busy_d = drain_busy_q;
    case (state_q)
      ST_IDLE: if (cpu_req && !cpu_we && !hit) begin
        state_d    = ST_WAIT;
        miss_blk_d = cpu_addr[ADDR_W-1:OFF_W];
      end
      ST_WAIT: if (fill_go) begin
        state_d    = ST_FILL;
        fill_cnt_d = '0;
      end
      ST_FILL: if (mem_ack) begin
        fill_cnt_d = fill_cnt_q + WSEL_W'(1);
        if (fill_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (drain_go)                     drain_busy_d = 1'b1;
    else if (drain_busy_q && mem_ack) drain_busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q      <= ST_IDLE;
      miss_blk_q   <= '0;
      fill_cnt_q   <= '0;
      drain_busy_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      miss_blk_q   <= miss_blk_d;
      fill_cnt_q   <= fill_cnt_d;
      drain_busy_q <= drain_busy_d;
    end
  end

  assign mem_req   = drain_busy_q || (state_q == ST_FILL);
  assign mem_we    = drain_busy_q;
  assign mem_addr  = drain_busy_q ? {wb_head.waddr, BSEL_W'(0)}
                                  : {miss_blk_q, fill_cnt_q, BSEL_W'(0)};
  assign mem_wdata = wb_head.data;
  assign mem_be    = drain_busy_q ? wb_head.be : '1;
endmodule

// File: rtl/wtc_checks.sv
module wtc_checks
  import wtc_pkg::*;
(
  input logic              clk,
  input logic              rst_i_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wb_full,
  input logic              wb_empty,
  input logic              wb_probe_hit
);
  // R7: a full queue takes no further store
  a_r7_full_blocks_store: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wb_full && cpu_req && cpu_we) |-> !cpu_ready);

  // R6: an accepted store is in the queue one cycle later
  a_r6_store_enters_queue: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_req && cpu_we && cpu_ready) |=> !wb_empty);

  // R9: no line read while a queued store targets the missed block
  a_r9_no_read_over_pending: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && !mem_we) |-> !wb_probe_hit);

  // R3: a memory request holds until it is acknowledged
  a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R2: a completing load never overlaps a line read
  a_r2_hit_no_fetch: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_req && !cpu_we && cpu_ready) |-> (!mem_req || mem_we));

  // R10: the memory port stays quiet while reset is applied
  always @(posedge clk) begin
    if (!rst_i_n) a_r10_quiet_in_reset: assert (!mem_req);
  end
endmodule

bind wtc_top wtc_checks u_checks (
  .clk          (clk),
  .rst_i_n      (rst_i_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_ready    (cpu_ready),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .wb_full      (wb_full),
  .wb_empty     (wb_empty),
  .wb_probe_hit (wb_probe_hit)
);

// File: tb/wtc_top_bench.sv
module wtc_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 2048;
  localparam int LOG_MAX    = 1024;

  logic        clk, rst_n;
  logic        cpu_req, cpu_we, cpu_ready;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic [3:0]  cpu_be;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  wtc_top u_wtc_top (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [31:0] model [MEM_WORDS];
  logic [31:0] arch  [MEM_WORDS];
  logic        log_we   [LOG_MAX];
  logic [31:0] log_addr [LOG_MAX];
  logic [31:0] log_data [LOG_MAX];
  logic [3:0]  log_be   [LOG_MAX];
  int log_n, w_cnt, n_stores, mem_lat, n_chk, n_bad;
  bit timed_out;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] seed_word(input int i);
    return (32'(i) * 32'h0100_0193) ^ 32'hC0DE_5A00;
  endfunction

  assign mem_rdata = model[mem_addr[12:2]];

  // Memory responder: acknowledges after mem_lat cycles of request.
  initial begin
    int wait_cnt;
    for (int i = 0; i < MEM_WORDS; i++) model[i] = seed_word(i);
    mem_ack = 1'b0; log_n = 0; w_cnt = 0; wait_cnt = 0;
    forever begin
      @(posedge clk);
      if (mem_req && mem_ack) begin
        if (log_n < LOG_MAX) begin
          log_we[log_n] <= mem_we; log_addr[log_n] <= mem_addr;
          log_data[log_n] <= mem_wdata; log_be[log_n] <= mem_be;
        end
        log_n <= log_n + 1;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) model[mem_addr[12:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          w_cnt <= w_cnt + 1;
        end
        mem_ack <= 1'b0; wait_cnt = 0;
      end else if (mem_req) begin
        if (wait_cnt + 1 >= mem_lat) mem_ack <= 1'b1;
        else wait_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_be = 4'hF; lat = 0;
    #1;
    while (!cpu_ready && !timed_out) begin @(negedge clk); #1; lat++; end
    d = cpu_rdata;
    @(posedge clk); #1; cpu_req = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] be, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_be = be; lat = 0;
    #1;
    while (!cpu_ready && !timed_out) begin @(negedge clk); #1; lat++; end
    for (int b = 0; b < 4; b++) if (be[b]) arch[a[12:2]][8*b +: 8] = d[8*b +: 8];
    n_stores++;
    @(posedge clk); #1; cpu_req = 1'b0;
  endtask

  task automatic drain_wait();
    while (w_cnt != n_stores && !timed_out) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [31:0] a, input string req, output int lat);
    logic [31:0] d;
    do_read(a, d, lat);
    check(d === arch[a[12:2]], req, $sformatf("load data @%h", a), d, arch[a[12:2]]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1'b1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int lat, s, iw, ir;
    int lats [6];
    logic [31:0] lfsr, a;
    bit ok;
    n_chk = 0; n_bad = 0; n_stores = 0; timed_out = 1'b0; mem_lat = 2;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
    for (int i = 0; i < MEM_WORDS; i++) arch[i] = seed_word(i);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R10: quiet after reset, empty queue produces no drain
    check(mem_req === 1'b0, "R10", "mem_req idle after reset", 32'(mem_req), 0);
    check(log_n == 0, "R10", "no memory traffic after reset", log_n, 0);

    // R1 R3 R10: cold sweep, every line misses and fills in ascending order
    for (int l = 0; l < 32; l++) begin
      s = log_n;
      rd_chk(32'(l*32 + 4*(l%8)), "R3", lat);
      check(lat >= 8, "R10", "cold load stalls", lat, 8);
      ok = (log_n - s == 8);
      for (int k = 0; k < 8; k++)
        if (s + k < LOG_MAX)
          ok &= (log_we[s+k] === 1'b0) && (log_addr[s+k] === 32'(l*32 + 4*k));
      check(ok, "R3", $sformatf("refill order line %0d", l), log_n - s, 8);
    end

    // R1 R2: every word of the first KB now hits with no memory traffic
    s = log_n;
    for (int w = 0; w < 256; w++) begin
      rd_chk(32'(w*4), "R1", lat);
      check(lat == 0, "R2", $sformatf("hit latency word %0d", w), lat, 0);
    end
    check(log_n == s, "R2", "hits issue no memory traffic", log_n - s, 0);

    // R1: same index, different tag evicts
    rd_chk(32'h0000_0408, "R1", lat);
    check(lat > 0, "R1", "conflicting tag misses", lat, 1);
    rd_chk(32'h0000_0004, "R1", lat);
    check(lat > 0, "R1", "evicted block misses again", lat, 1);
    rd_chk(32'h0000_0020, "R1", lat);
    check(lat == 0, "R1", "neighbour line unaffected", lat, 0);

    // R4 R6 R8: store hit merges bytes and drains with its enables
    s = log_n;
    do_write(32'h0000_0024, 32'hDEAD_BEEF, 4'b0101, lat);
    check(lat == 0, "R6", "store accepted at once", lat, 0);
    rd_chk(32'h0000_0024, "R4", lat);
    check(lat == 0, "R4", "merged word still hits", lat, 0);
    drain_wait();
    ok = (log_n - s == 1) && log_we[s] && (log_addr[s] === 32'h24) &&
         (log_data[s] === 32'hDEAD_BEEF) && (log_be[s] === 4'b0101);
    check(ok, "R8", "drain write fields", log_addr[s], 32'h24);

    // R5: store miss leaves resident block and does not allocate
    do_write(32'h0000_0848, 32'h1234_5678, 4'hF, lat);
    rd_chk(32'h0000_0048, "R5", lat);
    check(lat == 0, "R5", "resident block kept", lat, 0);
    drain_wait();
    rd_chk(32'h0000_0848, "R5", lat);
    check(lat > 0, "R5", "stored block not allocated", lat, 1);

    // R9: load miss to a block with a queued store waits for it
    mem_lat = 12;
    s = log_n;
    do_write(32'h0000_1068, 32'hCAFE_F00D, 4'b1100, lat);
    rd_chk(32'h0000_1068, "R9", lat);
    iw = -1; ir = -1;
    for (int i = s; i < log_n && i < LOG_MAX; i++) begin
      if (iw < 0 && log_we[i] && log_addr[i] === 32'h1068) iw = i;
      if (ir < 0 && !log_we[i] && log_addr[i][31:5] == 27'(32'h1068 >> 5)) ir = i;
    end
    check(iw >= 0 && ir > iw, "R9", "store drained before refill", ir, iw + 1);
    drain_wait();

    // R6 R7 R8: fill the queue under slow memory
    mem_lat = 15;
    s = log_n;
    for (int k = 0; k < 6; k++) begin
      do_write(32'h0000_1400 + 32'(4*k), 32'hA000_0000 + 32'(k), 4'hF, lat);
      lats[k] = lat;
    end
    for (int k = 0; k < 4; k++)
      check(lats[k] == 0, "R6", $sformatf("store %0d accepted", k), lats[k], 0);
    check(lats[4] >= 5, "R7", "fifth store held while full", lats[4], 5);
    drain_wait();
    ok = (log_n - s == 6);
    for (int k = 0; k < 6; k++)
      if (s + k < LOG_MAX)
        ok &= log_we[s+k] && (log_addr[s+k] === 32'h1400 + 32'(4*k)) &&
              (log_data[s+k] === 32'hA000_0000 + 32'(k));
    check(ok, "R8", "drain arrival order", log_n - s, 6);

    // R2 R3 R4 R8 R9: mixed traffic with varying latency
    lfsr = 32'h1D87_2B41;
    for (int n = 0; n < 400; n++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      mem_lat = 1 + int'(lfsr[27:26]);
      a = {19'd0, lfsr[12:2], 2'b00};
      if (lfsr[31]) do_write(a, lfsr ^ 32'h5555_AAAA, (lfsr[19:16] == 0) ? 4'h1 : lfsr[19:16], lat);
      else          rd_chk(a, "R4", lat);
    end
    drain_wait();
    ok = 1'b1;
    for (int i = 0; i < MEM_WORDS; i++) ok &= (model[i] === arch[i]);
    check(ok, "R8", "memory image after drain", w_cnt, n_stores);

    finish_run();
  end
endmodule